// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block is a synthesizable, byte-level model of a serial EEPROM target on a two-wire bus. A front end that is not part of this block decodes the bus into single-cycle events: START, STOP, a received byte, or a request for a byte to send. For every received byte the model answers with an acknowledge decision one cycle later. For every send request it returns a data byte one cycle later.

A transaction opens with a header byte. The header holds a fixed device type, three upper address bits and a direction bit. A write header is followed by two offset bytes. Data bytes then collect in a page buffer, and the in-page pointer wraps around inside the page. A STOP that ends a write with at least one data byte starts a timed internal write cycle. During that cycle the buffer is copied into the storage array and the model refuses its header, so a host can poll for completion. A read header after a repeated START streams bytes out from the latched address with no length limit.

Top module: `eeprom_tgt_model`

## Requirements
- R1: After reset, `busy_o`, `ack_valid_o` and `tx_valid_o` are 0.
- R2: Every received byte gets `ack_valid_o`=1 in the following cycle. A header byte (the first byte after START) is acknowledged (`ack_o`=1) only when its bits 7:4 equal 4'b1010, its bit 3 equals `strap_hi`, and no write cycle is running. Header bits 3:1 become address bits 18:16 and bit 0 is the direction (1 = read). Bits 2:1 are stored but never compared.
- R3: After a write header, two offset bytes are acknowledged: the first gives address bits 15:8 and the second gives bits 7:0. A storage location is the 19-bit address modulo `MEM_BYTES`.
- R4: Each data byte of a write is acknowledged and goes to the current address. Then only the low log2(`PAGE_BYTES`) address bits increment, so a write that passes the last byte of a page continues at that page's first byte.
- R5: A STOP that ends a write holding at least one data byte raises `busy_o` in the next cycle, and `busy_o` stays high for exactly `TWR_CYCLES` cycles. A STOP after a read, or after a write with no data byte, leaves `busy_o` low.
- R6: While `busy_o` is high, a header byte is answered with NACK, and every later byte up to the next START is also NACKed.
- R7: Written data reaches storage only through a write cycle. Data bytes followed by a repeated START instead of a STOP are discarded.
- R8: A read header after a repeated START reads from the address latched before it. Each send request returns `tx_valid_o`=1 with the stored byte in the next cycle, and the full 18-bit in-part address increments, across page boundaries, with no length limit.
- R9: Bytes in a transaction whose header was refused, and bytes received during a read, are NACKed and change no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_hi | input | 1 | Level the header's bit 3 must match |
| ev_start | input | 1 | START or repeated START event (one-cycle pulse) |
| ev_stop | input | 1 | STOP event |
| ev_rx_valid | input | 1 | A byte from the host is present |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_req | input | 1 | Host requests a byte from the target |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid_o | output | 1 | Returned byte valid |
| tx_byte_o | output | 8 | Returned byte (0xFF when not in a read) |
| busy_o | output | 1 | Internal write cycle running |

## Verification
A wrong transaction state shows up at the ports in the very next response. A byte that should be ACKed comes back NACKed, or the reverse. A wrong pointer cannot be seen right away. It appears only later, when a read returns a byte that the bench's shadow memory does not expect, which can be a full write cycle after the write. Sequential reads after wrapped writes and after discarded writes therefore carry most of the weight. An error in the write-cycle counter shows as a `busy_o` pulse with the wrong length, which is measured on every write.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } tgt_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         ADDR_W   = 19;
endpackage

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_BYTES = 256,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [PG_W-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output logic            rd_valid
);
    logic [PAGE_BYTES-1:0] mask_q;
    logic [7:0]            data_q [PAGE_BYTES];

    // valid bit per page slot; clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = mask_q[rd_idx];
endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_tgt_model.sv
module eeprom_tgt_model
    import eeprom_tgt_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    parameter int TWR_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_hi,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_rx_valid,
    input  logic [7:0] ev_rx_byte,
    input  logic       ev_tx_req,
    output logic       ack_valid_o,
    output logic       ack_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_byte_o,
    output logic       busy_o
);
    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int TW    = $clog2(TWR_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TWR_CYCLES - 1);

    typedef struct packed {
        tgt_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic              wr_any;
        logic              busy;
        logic [TW-1:0]     tcnt;
        logic              ack_valid;
        logic              ack;
        logic              tx_valid;
        logic [7:0]        tx_byte;
    } tgt_regs_t;

    tgt_regs_t s_q, s_d;

    logic             pb_clr, pb_wr, pb_rd_valid;
    logic [7:0]       pb_rd_data, mem_rdata;
    logic             mem_we;
    logic [PG_W-1:0]  commit_idx;
    logic [IDX_W-1:0] mem_waddr;
    logic             hdr_match;

    assign commit_idx = s_q.tcnt[PG_W-1:0];
    assign mem_waddr  = {s_q.ptr[IDX_W-1:PG_W], commit_idx};
    assign hdr_match  = (ev_rx_byte[7:4] == DEV_TYPE) &&
                        (ev_rx_byte[3] == strap_hi) && !s_q.busy;

    eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pb_clr),
        .wr_en    (pb_wr),
        .wr_idx   (s_q.ptr[PG_W-1:0]),
        .wr_data  (ev_rx_byte),
        .rd_idx   (commit_idx),
        .rd_data  (pb_rd_data),
        .rd_valid (pb_rd_valid)
    );

    eeprom_mem_array #(.DEPTH(MEM_BYTES)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (pb_rd_data),
        .raddr (s_q.ptr[IDX_W-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        s_d           = s_q;
        s_d.ack_valid = 1'b0;
        s_d.ack       = 1'b0;
        s_d.tx_valid  = 1'b0;
        pb_clr        = 1'b0;
        pb_wr         = 1'b0;
        mem_we        = 1'b0;

        // timed write cycle: copy one page slot per cycle, then release
        if (s_q.busy) begin
            mem_we = (32'(s_q.tcnt) < PAGE_BYTES) && pb_rd_valid;
            if (s_q.tcnt == T_LAST) begin
                s_d.busy = 1'b0;
                pb_clr   = 1'b1;
            end else begin
                s_d.tcnt = s_q.tcnt + 1'b1;
            end
        end

        if (ev_start) begin
            s_d.state = ST_DEV;
            if (!s_q.busy) begin
                pb_clr     = 1'b1;
                s_d.wr_any = 1'b0;
            end
        end else if (ev_stop) begin
            if (s_q.state == ST_WDATA && s_q.wr_any && !s_q.busy) begin
                s_d.busy = 1'b1;
                s_d.tcnt = '0;
            end
            s_d.wr_any = 1'b0;
            s_d.state  = ST_IDLE;
        end else if (ev_rx_valid) begin
            s_d.ack_valid = 1'b1;
            unique case (s_q.state)
                ST_DEV: begin
                    if (hdr_match) begin
                        s_d.ack        = 1'b1;
                        s_d.ptr[18:16] = ev_rx_byte[3:1];
                        s_d.state      = ev_rx_byte[0] ? ST_RDATA : ST_AHI;
                    end else begin
                        s_d.state = ST_SKIP;
                    end
                end
                ST_AHI: begin
                    s_d.ack       = 1'b1;
                    s_d.ptr[15:8] = ev_rx_byte;
                    s_d.state     = ST_ALO;
                end
                ST_ALO: begin
                    s_d.ack      = 1'b1;
                    s_d.ptr[7:0] = ev_rx_byte;
                    s_d.state    = ST_WDATA;
                end
                ST_WDATA: begin
                    s_d.ack             = 1'b1;
                    pb_wr               = 1'b1;
                    s_d.wr_any          = 1'b1;
                    s_d.ptr[PG_W-1:0]   = s_q.ptr[PG_W-1:0] + 1'b1;
                end
                default: s_d.ack = 1'b0;
            endcase
        end else if (ev_tx_req) begin
            s_d.tx_valid = 1'b1;
            if (s_q.state == ST_RDATA) begin
                s_d.tx_byte    = mem_rdata;
                s_d.ptr[17:0]  = s_q.ptr[17:0] + 18'd1;
            end else begin
                s_d.tx_byte = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= ST_IDLE;
            s_q.ptr       <= '0;
            s_q.wr_any    <= 1'b0;
            s_q.busy      <= 1'b0;
            s_q.tcnt      <= '0;
            s_q.ack_valid <= 1'b0;
            s_q.ack       <= 1'b0;
            s_q.tx_valid  <= 1'b0;
            s_q.tx_byte   <= 8'hFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_valid_o = s_q.ack_valid;
    assign ack_o       = s_q.ack;
    assign tx_valid_o  = s_q.tx_valid;
    assign tx_byte_o   = s_q.tx_byte;
    assign busy_o      = s_q.busy;
endmodule

// File: rtl/eeprom_tgt_checker.sv
module eeprom_tgt_checker
    import eeprom_tgt_pkg::*;
#(
    parameter int TWR_CYCLES = 300,
    localparam int TW = $clog2(TWR_CYCLES + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_stop,
    input logic        ev_rx_valid,
    input logic        ev_tx_req,
    input logic        ack_valid_o,
    input logic        ack_o,
    input logic        tx_valid_o,
    input logic        busy_o,
    input tgt_state_e  st_q,
    input logic        wr_any_q,
    input logic [TW-1:0] tcnt_q,
    input logic [18:0] ptr_q,
    input logic        mem_we
);
    localparam logic [TW-1:0] T_LAST = TW'(TWR_CYCLES - 1);

    p_rx_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_valid && !ev_start && !ev_stop) |=> ack_valid_o);

    p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_valid && !ev_start && !ev_stop && st_q == ST_DEV && busy_o)
        |=> (ack_valid_o && !ack_o));

    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start && st_q == ST_WDATA && wr_any_q && !busy_o)
        |=> busy_o);

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tcnt_q != T_LAST) |=> busy_o);

    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tcnt_q == T_LAST) |=> !busy_o);

    p_commit_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_o);

    p_page_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_valid && !ev_start && !ev_stop && st_q == ST_WDATA)
        |=> (ptr_q[18:8] == $past(ptr_q[18:8])));

    p_tx_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_req && !ev_start && !ev_stop && !ev_rx_valid) |=> tx_valid_o);

    p_skip_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_valid && !ev_start && !ev_stop && (st_q == ST_SKIP || st_q == ST_RDATA))
        |=> !ack_o);
endmodule

bind eeprom_tgt_model eeprom_tgt_checker #(.TWR_CYCLES(TWR_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .ev_rx_valid (ev_rx_valid),
    .ev_tx_req   (ev_tx_req),
    .ack_valid_o (ack_valid_o),
    .ack_o       (ack_o),
    .tx_valid_o  (tx_valid_o),
    .busy_o      (busy_o),
    .st_q        (s_q.state),
    .wr_any_q    (s_q.wr_any),
    .tcnt_q      (s_q.tcnt),
    .ptr_q       (s_q.ptr),
    .mem_we      (mem_we)
);

// File: tb/eeprom_tgt_model_tb.sv
module eeprom_tgt_model_tb;
    localparam int MEM = 1024;
    localparam int PG  = 256;
    localparam int TWR = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_hi = 1'b1;
    logic       ev_start = 1'b0, ev_stop = 1'b0, ev_rx_valid = 1'b0, ev_tx_req = 1'b0;
    logic [7:0] ev_rx_byte = 8'h00;
    logic       ack_valid_o, ack_o, tx_valid_o, busy_o;
    logic [7:0] tx_byte_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] ref_mem [MEM];
    bit         ref_known [MEM];
    logic [7:0] pend_d [PG];
    int         pend_a [PG];
    bit         pend_v [PG];

    always #4 clk = ~clk;

    eeprom_tgt_model #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_rx_valid(ev_rx_valid), .ev_rx_byte(ev_rx_byte), .ev_tx_req(ev_tx_req),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic [18:0] a, input bit rd);
        return {4'b1010, a[18:16], rd};
    endfunction

    function automatic int midx(input logic [18:0] a);
        return int'(a) % MEM;
    endfunction

    task automatic do_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output bit a);
        @(negedge clk) begin ev_rx_valid = 1'b1; ev_rx_byte = b; end
        @(negedge clk) ev_rx_valid = 1'b0;
        chk(ack_valid_o == 1'b1, "R2 ack_valid", int'(ack_valid_o), 1);
        a = ack_o;
    endtask

    task automatic recv(output logic [7:0] d);
        @(negedge clk) ev_tx_req = 1'b1;
        @(negedge clk) ev_tx_req = 1'b0;
        chk(tx_valid_o == 1'b1, "R8 tx_valid", int'(tx_valid_o), 1);
        d = tx_byte_o;
    endtask

    // busy is sampled right after STOP; counts the high cycles
    task automatic wait_busy(input bit expect_busy);
        int n = 0;
        while (busy_o && n < TWR + 10) begin
            n++;
            @(negedge clk);
        end
        if (expect_busy) chk(n == TWR, "R5 busy length", n, TWR);
        else             chk(n == 0, "R5 no write cycle", n, 0);
    endtask

    task automatic send_hdr_addr(input logic [18:0] a);
        bit k;
        send(hdr(a, 1'b0), k); chk(k, "R2 header ack", int'(k), 1);
        send(a[15:8], k);      chk(k, "R3 offset hi ack", int'(k), 1);
        send(a[7:0], k);       chk(k, "R3 offset lo ack", int'(k), 1);
    endtask

    // sends n data bytes; records into pending shadow (page wrap, R4)
    task automatic send_data(input logic [18:0] a, input int n);
        bit k;
        for (int i = 0; i < PG; i++) pend_v[i] = 0;
        for (int i = 0; i < n; i++) begin
            logic [18:0] wa;
            logic [7:0]  d;
            wa = {a[18:8], 8'(a[7:0] + 8'(i))};
            d  = 8'($urandom);
            send(d, k);
            chk(k, "R4 data ack", int'(k), 1);
            pend_v[i % PG] = 1;
            pend_a[i % PG] = midx(wa);
            pend_d[i % PG] = d;
        end
    endtask

    task automatic commit_pend();
        for (int i = 0; i < PG; i++)
            if (pend_v[i]) begin
                ref_mem[pend_a[i]]   = pend_d[i];
                ref_known[pend_a[i]] = 1;
            end
    endtask

    task automatic wr_txn(input logic [18:0] a, input int n);
        do_start();
        send_hdr_addr(a);
        send_data(a, n);
        do_stop();
        chk(busy_o == (n > 0), "R5 busy after stop", int'(busy_o), int'(n > 0));
        wait_busy(n > 0);
        if (n > 0) commit_pend();
    endtask

    task automatic rd_txn(input logic [18:0] a, input int n);
        bit k;
        logic [7:0] d;
        do_start();
        send_hdr_addr(a);
        do_start();
        send(hdr(a, 1'b1), k);
        chk(k, "R8 read header ack", int'(k), 1);
        for (int i = 0; i < n; i++) begin
            logic [18:0] ra;
            int ix;
            ra = {a[18], 18'(a[17:0] + 18'(i))};
            ix = midx(ra);
            recv(d);
            if (ref_known[ix])
                chk(d == ref_mem[ix], "R8 read data", int'(d), int'(ref_mem[ix]));
        end
        do_stop();
        chk(busy_o == 1'b0, "R5 no busy after read", int'(busy_o), 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        bit k;
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < MEM; i++) ref_known[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && ack_valid_o == 0 && tx_valid_o == 0, "R1 reset outputs",
            int'({busy_o, ack_valid_o, tx_valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5 R8 basic write then read back
        wr_txn(19'h40010, 4);
        rd_txn(19'h40010, 4);

        // R4 page wrap: 0xFE, 0xFF, then 0x00.. of the same page
        wr_txn(19'h401FE, 5);
        rd_txn(19'h40100, 3);
        // R8 read crossing a page boundary
        wr_txn(19'h40200, 2);
        rd_txn(19'h401FE, 4);

        // R6 header NACK during the write cycle, and later bytes too
        do_start();
        send_hdr_addr(19'h40300);
        send_data(19'h40300, 3);
        do_stop();
        do_start();
        send(hdr(19'h40300, 1'b0), k);
        chk(k == 0, "R6 header nack while busy", int'(k), 0);
        send(8'h03, k);
        chk(k == 0, "R6 following byte nack", int'(k), 0);
        do_stop();
        chk(busy_o == 1, "R6 cycle still running", int'(busy_o), 1);
        while (busy_o) @(negedge clk);
        commit_pend();
        rd_txn(19'h40300, 3);

        // R5 STOP with no data byte
        wr_txn(19'h40010, 0);
        rd_txn(19'h40010, 4);

        // R7 data then repeated START: discarded
        do_start();
        send_hdr_addr(19'h40010);
        send_data(19'h40010, 3);
        do_start();
        send_hdr_addr(19'h40011);
        do_start();
        send(hdr(19'h40011, 1'b1), k);
        chk(k, "R8 read after repeated start", int'(k), 1);
        recv(d);
        chk(d == ref_mem[midx(19'h40011)], "R7 discarded write, latched addr",
            int'(d), int'(ref_mem[midx(19'h40011)]));
        do_stop();
        chk(busy_o == 0, "R7 no write cycle", int'(busy_o), 0);
        rd_txn(19'h40010, 4);

        // R9 refused headers: wrong strap bit, wrong type
        do_start();
        send({4'b1010, 3'b000, 1'b0}, k);
        chk(k == 0, "R2 strap mismatch nack", int'(k), 0);
        send(8'h00, k); chk(k == 0, "R9 byte after refusal", int'(k), 0);
        send(8'h10, k); chk(k == 0, "R9 byte after refusal", int'(k), 0);
        send(8'h55, k); chk(k == 0, "R9 byte after refusal", int'(k), 0);
        do_stop();
        chk(busy_o == 0, "R9 no write cycle", int'(busy_o), 0);
        do_start();
        send({4'b1011, 3'b100, 1'b0}, k);
        chk(k == 0, "R2 wrong type nack", int'(k), 0);
        do_stop();
        // R9 byte received during a read is NACKed
        do_start();
        send_hdr_addr(19'h40010);
        do_start();
        send(hdr(19'h40010, 1'b1), k);
        send(8'hAA, k);
        chk(k == 0, "R9 byte during read nack", int'(k), 0);
        do_stop();
        rd_txn(19'h40010, 4);

        // R2: bits 2:1 are not compared
        do_start();
        send({4'b1010, 3'b111, 1'b0}, k);
        chk(k == 1, "R2 bits 2:1 ignored", int'(k), 1);
        do_stop();

        // random mix
        for (int it = 0; it < 14; it++) begin
            logic [18:0] a;
            int n;
            a = {1'b1, 18'($urandom)};
            n = 1 + int'($urandom % 40);
            wr_txn(a, n);
            rd_txn(a, n);
        end

        done = 1;
        finish_run();
    end
endmodule